// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block turns a pixel clock into the timing skeleton of a video raster. Software programs the line and frame geometry through a small write-only register file. The block then produces a horizontal pixel counter, a vertical line counter, an active-video flag, horizontal and vertical sync, a composite sync meant to ride on a colour channel, a per-line early-fetch strobe and a one-clock frame-start pulse. The fetch strobe tells a pixel pipeline ahead of time that a new line is coming.

Every geometry value is stored as a count minus one, so the largest legal value is the last position of its range. Geometry writes first land in a shadow copy, and the running copy reloads only at a frame boundary or while timing is disabled, so reprogramming cannot tear a line. The sync output stage applies per-channel polarity inversion. It also applies per-channel suppression and an all-sync-off control, which software combines with a display-off bit to build the usual power-saving blanking states.

Top module: `dtg_top`

## Requirements
- R1: After reset both counters are zero, and hsync, vsync, colour_sync, active, prefetch and frame_start are all low.
- R2: Control register (address 0) bit 0 is the timing enable and bit 1 is the refresh enable. While bit 0 is clear, both counters are held at zero, frame_start stays low and each sync sits at its inactive level (low, or high when that sync is inverted).
- R3: With timing enabled, h_count steps 0..HTOT and wraps to 0. Each wrap advances v_count, which steps 0..VTOT and wraps to 0, so a line lasts HTOT+1 clocks and a frame lasts (HTOT+1)*(VTOT+1) clocks. Geometry addresses: 1 HTOT, 2 last active pixel, 3 hsync start, 4 hsync end, 5 VTOT, 6 last active line, 7 vsync start, 8 vsync end, 9 fetch position.
- R4: frame_start is high for exactly the clock in which timing is enabled and both counters are zero.
- R5: active is high when both control bits are set, h_count is at most the last active pixel and v_count is at most the last active line.
- R6: The raw hsync window is h_count within [hsync start, hsync end], inclusive at both ends. The raw vsync window is v_count within [vsync start, vsync end], inclusive at both ends. Sync control register (address 10) bit 3 inverts hsync and bit 4 inverts vsync.
- R7: In the sync control register, bit 5 suppresses hsync, bit 6 suppresses vsync and bit 1 suppresses both. A suppressed sync rests at its inactive level.
- R8: When sync control bit 0 is set, colour_sync is high whenever an unsuppressed raw sync window (hsync or vsync) is open. Otherwise colour_sync is low.
- R9: prefetch is high for one clock per line, when h_count equals the fetch position, provided both control bits are set.
- R10: Display control register (address 11) bit 1 forces active low.
- R11: Geometry writes are double-buffered. The running geometry reloads from the shadow copy only on the clock where the counters wrap from (HTOT, VTOT) to (0, 0), or on any clock while timing is disabled.
- R12: Writes to addresses 12 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | CW | Register write data |
| h_count | output | CW | Pixel position within the line |
| v_count | output | CW | Line position within the frame |
| active | output | 1 | Active video |
| hsync | output | 1 | Horizontal sync after polarity and suppression |
| vsync | output | 1 | Vertical sync after polarity and suppression |
| colour_sync | output | 1 | Composite sync for a colour channel, active high |
| prefetch | output | 1 | Early per-line fetch strobe |
| frame_start | output | 1 | One clock at counter origin |

## Verification
The bench builds the block with its default 12-bit counter width and programs tiny rasters of 20x12 and 25x10 clocks. A whole frame therefore fits in a few hundred cycles, and frame wrap, the vertical sync window, geometry reload and every blanking combination are all reached many times over. The second geometry is written while a frame is running, and its hsync end sits on the last pixel of the line, which probes the inclusive window end and the deferred reload. A behavioural model with its own counters and shadow copies is compared on every clock against all outputs, and the measured frame and line periods are checked against the product of the programmed totals.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  localparam int unsigned ADDR_W = 4;
  localparam int unsigned NGEO   = 9;

  // register addresses
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_GEO0  = 4'd1;   // first geometry slot
  localparam logic [ADDR_W-1:0] A_SYNC  = 4'd10;
  localparam logic [ADDR_W-1:0] A_DISP  = 4'd11;

  // geometry slot indices (address minus A_GEO0)
  localparam int GI_HTOT  = 0;
  localparam int GI_HLAST = 1;
  localparam int GI_HSS   = 2;
  localparam int GI_HSE   = 3;
  localparam int GI_VTOT  = 4;
  localparam int GI_VLAST = 5;
  localparam int GI_VSS   = 6;
  localparam int GI_VSE   = 7;
  localparam int GI_FETCH = 8;

  // sync control bit positions
  localparam int SC_COLOUR = 0;
  localparam int SC_ALLOFF = 1;
  localparam int SC_HINV   = 3;
  localparam int SC_VINV   = 4;
  localparam int SC_HOFF   = 5;
  localparam int SC_VOFF   = 6;

  // display control bit position
  localparam int DC_OFF = 1;

  // inclusive window test
  function automatic logic in_window(input logic [31:0] pos,
                                     input logic [31:0] lo,
                                     input logic [31:0] hi);
    return (pos >= lo) && (pos <= hi);
  endfunction

  // next position of a wrapping counter
  function automatic logic [31:0] wrap_next(input logic [31:0] pos,
                                            input logic [31:0] last);
    return (pos == last) ? 32'd0 : pos + 32'd1;
  endfunction

endpackage

// File: rtl/dtg_regfile.sv
module dtg_regfile
  import dtg_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic              frame_load,
  output logic              timing_en,
  output logic              refresh_en,
  output logic              sc_colour,
  output logic              sc_all_off,
  output logic              sc_inv_h,
  output logic              sc_inv_v,
  output logic              sc_off_h,
  output logic              sc_off_v,
  output logic              disp_off,
  output logic [CW-1:0]     geo_act [NGEO]
);

  logic [CW-1:0] geo_shadow [NGEO];

  // immediate control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timing_en  <= 1'b0;
      refresh_en <= 1'b0;
      sc_colour  <= 1'b0;
      sc_all_off <= 1'b0;
      sc_inv_h   <= 1'b0;
      sc_inv_v   <= 1'b0;
      sc_off_h   <= 1'b0;
      sc_off_v   <= 1'b0;
      disp_off   <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == A_CTRL) begin
        timing_en  <= wr_data[0];
        refresh_en <= wr_data[1];
      end
      if (wr_addr == A_SYNC) begin
        sc_colour  <= wr_data[SC_COLOUR];
        sc_all_off <= wr_data[SC_ALLOFF];
        sc_inv_h   <= wr_data[SC_HINV];
        sc_inv_v   <= wr_data[SC_VINV];
        sc_off_h   <= wr_data[SC_HOFF];
        sc_off_v   <= wr_data[SC_VOFF];
      end
      if (wr_addr == A_DISP) begin
        disp_off <= wr_data[DC_OFF];
      end
    end
  end

  // double-buffered geometry: shadow written by software, running copy
  // reloaded from the old shadow value on a frame boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NGEO; g++) begin
        geo_shadow[g] <= '0;
        geo_act[g]    <= '0;
      end
    end else begin
      for (int g = 0; g < NGEO; g++) begin
        if (frame_load) geo_act[g] <= geo_shadow[g];
        if (wr_en && wr_addr == ADDR_W'(g + 1)) geo_shadow[g] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/dtg_counters.sv
module dtg_counters
  import dtg_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          timing_en,
  input  logic [CW-1:0] htot,
  input  logic [CW-1:0] vtot,
  output logic [CW-1:0] h_count,
  output logic [CW-1:0] v_count,
  output logic          frame_wrap
);

  logic line_end;

  assign line_end   = timing_en && (h_count == htot);
  assign frame_wrap = line_end && (v_count == vtot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_count <= '0;
      v_count <= '0;
    end else if (!timing_en) begin
      h_count <= '0;
      v_count <= '0;
    end else begin
      h_count <= CW'(wrap_next(32'(h_count), 32'(htot)));
      if (line_end) v_count <= CW'(wrap_next(32'(v_count), 32'(vtot)));
    end
  end

endmodule

// File: rtl/dtg_sync_stage.sv
module dtg_sync_stage
  import dtg_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic          timing_en,
  input  logic [CW-1:0] h_count,
  input  logic [CW-1:0] v_count,
  input  logic [CW-1:0] hs_start,
  input  logic [CW-1:0] hs_end,
  input  logic [CW-1:0] vs_start,
  input  logic [CW-1:0] vs_end,
  input  logic          sc_colour,
  input  logic          sc_all_off,
  input  logic          sc_inv_h,
  input  logic          sc_inv_v,
  input  logic          sc_off_h,
  input  logic          sc_off_v,
  output logic          hsync,
  output logic          vsync,
  output logic          colour_sync
);

  localparam int NCH = 2;   // channel 0 horizontal, 1 vertical

  logic [CW-1:0] pos [NCH];
  logic [CW-1:0] lo  [NCH];
  logic [CW-1:0] hi  [NCH];
  logic [NCH-1:0] inv, off, win, keep, pin;

  assign pos[0] = h_count;  assign lo[0] = hs_start;  assign hi[0] = hs_end;
  assign pos[1] = v_count;  assign lo[1] = vs_start;  assign hi[1] = vs_end;
  assign inv = {sc_inv_v, sc_inv_h};
  assign off = {sc_off_v, sc_off_h};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign win[c]  = timing_en && in_window(32'(pos[c]), 32'(lo[c]), 32'(hi[c]));
    assign keep[c] = win[c] && !off[c] && !sc_all_off;
    assign pin[c]  = keep[c] ^ inv[c];
  end

  assign hsync       = pin[0];
  assign vsync       = pin[1];
  assign colour_sync = sc_colour && (|keep);

endmodule

// File: rtl/dtg_top.sv
module dtg_top
  import dtg_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] h_count,
  output logic [CW-1:0] v_count,
  output logic          active,
  output logic          hsync,
  output logic          vsync,
  output logic          colour_sync,
  output logic          prefetch,
  output logic          frame_start
);

  logic          timing_en, refresh_en, disp_off;
  logic          sc_colour, sc_all_off, sc_inv_h, sc_inv_v, sc_off_h, sc_off_v;
  logic          frame_wrap, frame_load, raster_on;
  logic [CW-1:0] geo_act [NGEO];
  logic [CW-1:0] htot_act;

  assign frame_load = !timing_en || frame_wrap;
  assign htot_act   = geo_act[GI_HTOT];
  assign raster_on  = timing_en && refresh_en;

  dtg_regfile #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .frame_load(frame_load),
    .timing_en(timing_en), .refresh_en(refresh_en),
    .sc_colour(sc_colour), .sc_all_off(sc_all_off),
    .sc_inv_h(sc_inv_h), .sc_inv_v(sc_inv_v),
    .sc_off_h(sc_off_h), .sc_off_v(sc_off_v),
    .disp_off(disp_off), .geo_act(geo_act)
  );

  dtg_counters #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .timing_en(timing_en),
    .htot(geo_act[GI_HTOT]), .vtot(geo_act[GI_VTOT]),
    .h_count(h_count), .v_count(v_count), .frame_wrap(frame_wrap)
  );

  dtg_sync_stage #(.CW(CW)) u_sync (
    .timing_en(timing_en), .h_count(h_count), .v_count(v_count),
    .hs_start(geo_act[GI_HSS]), .hs_end(geo_act[GI_HSE]),
    .vs_start(geo_act[GI_VSS]), .vs_end(geo_act[GI_VSE]),
    .sc_colour(sc_colour), .sc_all_off(sc_all_off),
    .sc_inv_h(sc_inv_h), .sc_inv_v(sc_inv_v),
    .sc_off_h(sc_off_h), .sc_off_v(sc_off_v),
    .hsync(hsync), .vsync(vsync), .colour_sync(colour_sync)
  );

  assign active = raster_on && !disp_off &&
                  (h_count <= geo_act[GI_HLAST]) && (v_count <= geo_act[GI_VLAST]);
  assign prefetch    = raster_on && (h_count == geo_act[GI_FETCH]);
  assign frame_start = timing_en && (h_count == '0) && (v_count == '0);

endmodule

// File: rtl/dtg_checker.sv
module dtg_checker #(
  parameter int unsigned CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          timing_en,
  input logic          refresh_en,
  input logic          frame_load,
  input logic [CW-1:0] htot_act,
  input logic [CW-1:0] h_count,
  input logic [CW-1:0] v_count,
  input logic          sc_all_off,
  input logic          sc_inv_h,
  input logic          sc_inv_v,
  input logic          disp_off,
  input logic          active,
  input logic          hsync,
  input logic          vsync,
  input logic          prefetch,
  input logic          frame_start
);

  a_r2_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !timing_en |=> (h_count == '0 && v_count == '0));

  a_r3_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (timing_en && h_count == htot_act) |=> (h_count == '0));

  a_r3_pixel_step: assert property (@(posedge clk) disable iff (!rst_n)
    (timing_en && h_count != htot_act) |=> (h_count == CW'($past(h_count) + 1'b1)));

  a_r4_frame_origin: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (timing_en && h_count == '0 && v_count == '0));

  a_r7_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (timing_en && sc_all_off) |-> (hsync == sc_inv_h && vsync == sc_inv_v));

  a_r9_prefetch_gate: assert property (@(posedge clk) disable iff (!rst_n)
    prefetch |-> (timing_en && refresh_en));

  a_r10_disp_off: assert property (@(posedge clk) disable iff (!rst_n)
    disp_off |-> !active);

  a_r11_geometry_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_load |=> $stable(htot_act));

endmodule

bind dtg_top dtg_checker #(.CW(CW)) u_dtg_checker (
  .clk(clk), .rst_n(rst_n), .timing_en(timing_en), .refresh_en(refresh_en),
  .frame_load(frame_load), .htot_act(htot_act),
  .h_count(h_count), .v_count(v_count),
  .sc_all_off(sc_all_off), .sc_inv_h(sc_inv_h), .sc_inv_v(sc_inv_v),
  .disp_off(disp_off), .active(active), .hsync(hsync), .vsync(vsync),
  .prefetch(prefetch), .frame_start(frame_start)
);

// File: tb/test_dtg_top.sv
`timescale 1ns/1ps
module test_dtg_top;

  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [CW-1:0] h_count, v_count;
  logic          active, hsync, vsync, colour_sync, prefetch, frame_start;

  always #4 clk = ~clk;   // 125 MHz

  dtg_top #(.CW(CW)) i_dtg_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .h_count(h_count), .v_count(v_count), .active(active), .hsync(hsync),
    .vsync(vsync), .colour_sync(colour_sync), .prefetch(prefetch),
    .frame_start(frame_start)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit compare_on = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int cyc = 0;
  int m_h, m_v, m_ctl, m_sc, m_dc;
  int m_sh [9];
  int m_ac [9];
  bit m_en, m_load;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_h = 0; m_v = 0; m_ctl = 0; m_sc = 0; m_dc = 0;
      for (int i = 0; i < 9; i++) begin m_sh[i] = 0; m_ac[i] = 0; end
    end else begin
      m_en   = m_ctl[0];
      m_load = !m_en || (m_h == m_ac[0] && m_v == m_ac[4]);
      if (!m_en) begin
        m_h = 0; m_v = 0;
      end else if (m_h == m_ac[0]) begin
        m_h = 0;
        m_v = (m_v == m_ac[4]) ? 0 : m_v + 1;
      end else begin
        m_h = m_h + 1;
      end
      if (m_load) for (int i = 0; i < 9; i++) m_ac[i] = m_sh[i];
      if (wr_en) begin
        if (wr_addr == 0) m_ctl = int'(wr_data) & 3;
        else if (wr_addr >= 1 && wr_addr <= 9) m_sh[int'(wr_addr) - 1] = int'(wr_data);
        else if (wr_addr == 10) m_sc = int'(wr_data) & 'h7F;
        else if (wr_addr == 11) m_dc = int'(wr_data) & 2;
      end
    end
  end

  // expected outputs from model state, compared away from the active edge
  bit e_en, e_ref, e_hw, e_vw, e_hk, e_vk;
  always @(negedge clk) begin
    if (rst_n && compare_on) begin
      e_en  = m_ctl[0];
      e_ref = m_ctl[1];
      e_hw  = e_en && m_h >= m_ac[2] && m_h <= m_ac[3];
      e_vw  = e_en && m_v >= m_ac[6] && m_v <= m_ac[7];
      e_hk  = e_hw && !m_sc[5] && !m_sc[1];
      e_vk  = e_vw && !m_sc[6] && !m_sc[1];
      chk("R3", "h_count", int'(h_count), m_h);
      chk("R3", "v_count", int'(v_count), m_v);
      chk("R4", "frame_start", int'(frame_start), int'(e_en && m_h == 0 && m_v == 0));
      chk("R5/R10", "active", int'(active),
          int'(e_en && e_ref && !m_dc[1] && m_h <= m_ac[1] && m_v <= m_ac[5]));
      chk("R6/R7", "hsync", int'(hsync), int'(e_hk ^ m_sc[3]));
      chk("R6/R7", "vsync", int'(vsync), int'(e_vk ^ m_sc[4]));
      chk("R8", "colour_sync", int'(colour_sync), int'(m_sc[0] && (e_hk || e_vk)));
      chk("R9", "prefetch", int'(prefetch), int'(e_en && e_ref && m_h == m_ac[8]));
    end
  end

  // period and pulse-count measurement at the ports
  int last_fs = -1, fs_period = 0, last_pf = -1, pf_period = 0;
  int hs_cnt = 0, act_cnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_start) begin
        if (last_fs >= 0) fs_period = cyc - last_fs;
        last_fs = cyc;
      end
      if (prefetch) begin
        if (last_pf >= 0) pf_period = cyc - last_pf;
        last_pf = cyc;
      end
      if (hsync) hs_cnt++;
      if (active) act_cnt++;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[3:0]; wr_data = d[CW-1:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    finish_run();
  end

  initial begin
    run(4);
    rst_n = 1'b1;
    run(1);
    // R1: reset state
    chk("R1", "h_count", int'(h_count), 0);
    chk("R1", "v_count", int'(v_count), 0);
    chk("R1", "syncs", int'({hsync, vsync, colour_sync}), 0);
    chk("R1", "flags", int'({active, prefetch, frame_start}), 0);
    compare_on = 1'b1;

    // geometry A while disabled: 20 x 12 raster
    wr(1, 19); wr(2, 15); wr(3, 16); wr(4, 17);
    wr(5, 11); wr(6, 7);  wr(7, 8);  wr(8, 9);  wr(9, 14);
    wr(0, 3);
    run(500);
    chk("R3", "frame period", fs_period, 240);
    chk("R9", "line period via prefetch", pf_period, 20);
    hs_cnt = 0;
    run(240);
    chk("R6", "hsync clocks per frame", hs_cnt, 2 * 12);

    // sync output stage combinations (R6 inversion, R7 suppression, R8 colour)
    wr(10, 'h18); run(260);
    wr(10, 'h20); run(260);
    wr(10, 'h40); run(260);
    wr(10, 'h02); run(260);
    wr(10, 'h01); run(260);
    wr(10, 'h21); run(260);
    wr(10, 'h00);

    // R10: display off
    wr(11, 2);
    act_cnt = 0;
    run(260);
    chk("R10", "active clocks while display off", act_cnt, 0);
    wr(11, 0);

    // R5/R9: refresh disabled
    wr(0, 1);
    act_cnt = 0;
    run(260);
    chk("R5", "active clocks with refresh off", act_cnt, 0);
    wr(0, 3);

    // R12: unmapped addresses
    wr(13, 'hFFF); wr(12, 0); wr(15, 0);
    run(500);
    chk("R12", "frame period after unmapped writes", fs_period, 240);

    // R11: reprogram mid-frame, 25 x 10 raster, hsync end on last pixel
    run(37);
    wr(1, 24); wr(2, 19); wr(3, 20); wr(4, 24);
    wr(5, 9);  wr(6, 6);  wr(7, 7);  wr(8, 8);  wr(9, 3);
    run(600);
    chk("R11", "frame period after reload", fs_period, 250);
    chk("R9", "line period after reload", pf_period, 25);

    // R2: disable with inverted syncs
    wr(10, 'h18);
    wr(0, 0);
    run(50);
    chk("R2", "h_count held", int'(h_count), 0);
    chk("R2", "v_count held", int'(v_count), 0);
    chk("R2", "hsync inactive inverted", int'(hsync), 1);
    chk("R2", "vsync inactive inverted", int'(vsync), 1);
    chk("R2", "frame_start low", int'(frame_start), 0);

    wr(0, 3);
    run(300);
    finish_run();
  end

endmodule